// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block drives the parallel programming pins of a small microcontroller's on-chip flash on behalf of a host. A host starts a job by giving a page-aligned start address and a page count. The sequencer first reads two identification bytes and compares them with expected values. It then reads the hardware security byte. If that byte shows any protection bit active, it runs a recovery path before any write. The recovery path unlocks the test modes, erases the chip, sets the security byte back to FFh, and writes the identification bytes back into the extra area.

It then opens programming access with a two-pulse unlock pattern. The host streams the page bytes over a valid/ready interface. Each byte is written with one program strobe while its address and data are held on the pins. A final lock strobe closes programming access.

Every operation has the same timing. The mode pattern, address and data are placed on the pins and held for a setup count. For writes, the active-low strobe is then driven low for a fixed width and released. The pins stay unchanged for a hold count after the strobe rises. Mode codes, identification addresses, expected bytes and all counts are parameters.

Top module: `flash_prog_seq`

## Requirements
- R1: A start pulse is taken only while idle and only when bits 6..0 of `start_addr` are zero (128-byte page alignment). In any other case it is ignored: `busy` stays 0 and `done` and `err` keep their values.
- R2: A job first reads with mode code 8'h10 at addresses 16'h0030 and 16'h0031 and compares the results with 8'h58 and 8'hD7. On a mismatch the job ends with `done`=1 and `err`=1, and no strobe is given.
- R3: After the identification check, a read with mode code 8'h11 at address 0 returns the security byte. A value other than 8'hFF makes the job give these strobes, in order, before the unlock pair of R4:
  - unlock pair (mode 8'h20, data 55h then AAh, address 0);
  - erase (mode 8'h21, address 0, data 0);
  - security write (mode 8'h22, address 0, data FFh);
  - extra-area writes (mode 8'h23) of the two identification bytes at 16'h0030 and 16'h0031.
- R4: Programming access is opened with two strobes in mode 8'h20 at address 0, carrying 55h first and AAh second.
- R5: With `start_pages`=N, the job then gives 128·N strobes in mode 8'h30. Strobe i carries address `start_addr`+i and the i-th streamed byte. `pin_doe` is 1 during every strobe.
- R6: The job ends with one strobe in mode 8'h40 at address 0 with data 0. After that strobe, `done`=1, `busy`=0 and `err`=0.
- R7: Mode, address and data pins are unchanged for at least SETUP_CLKS (2) clocks before each strobe falls.
- R8: `prog_n` stays low for exactly LOW_CLKS (3) clocks per strobe, and mode, address and data do not change while it is low.
- R9: Mode, address and data pins are unchanged for at least HOLD_CLKS (2) clocks after each strobe rises.
- R10: `s_ready` is 1 only while the job is busy and waiting for a page byte. Exactly one byte is taken per valid/ready handshake, and bytes beyond 128·N are never taken.
- R11: `done` and `err` hold their values until the next accepted start. `done` and `busy` are never 1 together, and `err` implies `done`.
- R12: After reset: `busy`=0, `done`=0, `err`=0, `prog_n`=1, `s_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job start pulse |
| start_addr | input | 16 | First page address, must be 128-byte aligned |
| start_pages | input | 8 | Number of 128-byte pages to write |
| s_valid | input | 1 | Host byte valid |
| s_data | input | 8 | Host byte |
| s_ready | output | 1 | Sequencer ready to take a byte |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished (held) |
| err | output | 1 | Last job failed the identification check (held) |
| pin_ctrl | output | 8 | Mode-select pin pattern |
| pin_addr | output | 16 | Address pins |
| pin_dout | output | 8 | Data driven to the flash |
| pin_doe | output | 1 | Data output enable (0 during reads) |
| pin_din | input | 8 | Data read from the flash |
| prog_n | output | 1 | Active-low program strobe |

## Verification
The assertions assume that `pin_din` is driven combinationally from the mode and address pins, as a flash in read mode would do. They also assume that the host holds `s_data` steady whenever it asserts `s_valid`. The bench meets both assumptions. Its target model answers reads only from the current mode and address. Its stream driver changes the byte only after a handshake, and it inserts idle gaps to vary the timing. No assertion constrains when `start` arrives, so the bench also pulses it with an unaligned address while the block is idle.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SIG0, S_SIG1, S_HSB, S_UNL0, S_UNL1, S_ERASE,
    S_HSBW, S_XA0, S_XA1, S_WAIT, S_LOAD, S_LOCK
  } seq_state_t;

  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_LOW, P_HOLD} strobe_ph_t;
endpackage

// File: rtl/fps_strobe.sv
module fps_strobe import fps_pkg::*; #(
  parameter int SETUP_CLKS = 2,
  parameter int LOW_CLKS   = 3,
  parameter int HOLD_CLKS  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic with_pulse,
  output logic busy,
  output logic done,
  output logic prog_n
);
  localparam int MAXC = (SETUP_CLKS > LOW_CLKS) ?
                        ((SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS) :
                        ((LOW_CLKS > HOLD_CLKS) ? LOW_CLKS : HOLD_CLKS);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SET_END  = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] LOW_END  = CW'(LOW_CLKS - 1);
  localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CLKS - 1);

  strobe_ph_t    ph;
  logic [CW-1:0] cnt;
  logic          pulse_q;

  assign busy = (ph != P_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= P_IDLE;
      cnt     <= '0;
      pulse_q <= 1'b0;
      done    <= 1'b0;
      prog_n  <= 1'b1;
    end else begin
      done <= 1'b0;
      case (ph)
        P_IDLE: if (go) begin
          ph      <= P_SETUP;
          cnt     <= '0;
          pulse_q <= with_pulse;
        end
        P_SETUP: if (cnt == SET_END) begin
          cnt <= '0;
          if (pulse_q) begin
            ph     <= P_LOW;
            prog_n <= 1'b0;
          end else begin
            ph   <= P_IDLE;
            done <= 1'b1;
          end
        end else cnt <= cnt + 1'b1;
        P_LOW: if (cnt == LOW_END) begin
          cnt    <= '0;
          ph     <= P_HOLD;
          prog_n <= 1'b1;
        end else cnt <= cnt + 1'b1;
        P_HOLD: if (cnt == HOLD_END) begin
          cnt  <= '0;
          ph   <= P_IDLE;
          done <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: ph <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fps_addr.sv
module fps_addr #(
  parameter int AW         = 16,
  parameter int PGW        = 8,
  parameter int PAGE_BYTES = 128
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [AW-1:0]  base,
  input  logic [PGW-1:0] pages,
  output logic           aligned,
  output logic [AW-1:0]  addr,
  output logic           last,
  output logic           empty
);
  localparam int PBITS = $clog2(PAGE_BYTES);
  localparam int LW    = PGW + PBITS;

  logic [LW-1:0] left;

  assign aligned = (base[PBITS-1:0] == '0);
  assign last    = (left == LW'(1));
  assign empty   = (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      left <= '0;
    end else if (load) begin
      addr <= base;
      left <= {pages, {PBITS{1'b0}}};
    end else if (step) begin
      addr <= addr + 1'b1;
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq import fps_pkg::*; #(
  parameter int AW         = 16,
  parameter int PGW        = 8,
  parameter int PAGE_BYTES = 128,
  parameter int SETUP_CLKS = 2,
  parameter int LOW_CLKS   = 3,
  parameter int HOLD_CLKS  = 2,
  parameter logic [AW-1:0] SIG_ADDR0 = 16'h0030,
  parameter logic [AW-1:0] SIG_ADDR1 = 16'h0031,
  parameter logic [AW-1:0] HSB_ADDR  = 16'h0000,
  parameter logic [7:0] SIG_EXP0   = 8'h58,
  parameter logic [7:0] SIG_EXP1   = 8'hD7,
  parameter logic [7:0] MODE_IDLE  = 8'h00,
  parameter logic [7:0] MODE_SIG   = 8'h10,
  parameter logic [7:0] MODE_HSB   = 8'h11,
  parameter logic [7:0] MODE_UNL   = 8'h20,
  parameter logic [7:0] MODE_ERASE = 8'h21,
  parameter logic [7:0] MODE_HSBW  = 8'h22,
  parameter logic [7:0] MODE_XAF   = 8'h23,
  parameter logic [7:0] MODE_LOAD  = 8'h30,
  parameter logic [7:0] MODE_LOCK  = 8'h40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [AW-1:0]  start_addr,
  input  logic [PGW-1:0] start_pages,
  input  logic           s_valid,
  input  logic [7:0]     s_data,
  output logic           s_ready,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [7:0]     pin_ctrl,
  output logic [AW-1:0]  pin_addr,
  output logic [7:0]     pin_dout,
  output logic           pin_doe,
  input  logic [7:0]     pin_din,
  output logic           prog_n
);
  seq_state_t     state;
  logic           armed, recov;
  logic [7:0]     sig0_q, sig1_q, byte_q;
  logic           eng_busy, eng_done, go, with_pulse, is_op;
  logic           aligned, last, empty, start_ok, step;
  logic [AW-1:0]  cur_addr;
  logic [7:0]     nxt_ctrl, nxt_dout;
  logic [AW-1:0]  nxt_addr;
  logic           nxt_doe;

  assign is_op      = (state != S_IDLE) && (state != S_WAIT);
  assign go         = is_op && !armed && !eng_busy;
  assign with_pulse = !(state inside {S_SIG0, S_SIG1, S_HSB});
  assign start_ok   = (state == S_IDLE) && start && aligned;
  assign step       = eng_done && (state == S_LOAD);
  assign s_ready    = (state == S_WAIT);

  fps_strobe #(.SETUP_CLKS(SETUP_CLKS), .LOW_CLKS(LOW_CLKS), .HOLD_CLKS(HOLD_CLKS)) u_strobe (
    .clk(clk), .rst(rst), .go(go), .with_pulse(with_pulse),
    .busy(eng_busy), .done(eng_done), .prog_n(prog_n));

  fps_addr #(.AW(AW), .PGW(PGW), .PAGE_BYTES(PAGE_BYTES)) u_addr (
    .clk(clk), .rst(rst), .load(start_ok), .step(step),
    .base(start_addr), .pages(start_pages), .aligned(aligned),
    .addr(cur_addr), .last(last), .empty(empty));

  always_comb begin
    nxt_ctrl = MODE_IDLE;
    nxt_addr = '0;
    nxt_dout = 8'h00;
    nxt_doe  = 1'b1;
    case (state)
      S_SIG0:  begin nxt_ctrl = MODE_SIG;   nxt_addr = SIG_ADDR0; nxt_doe = 1'b0; end
      S_SIG1:  begin nxt_ctrl = MODE_SIG;   nxt_addr = SIG_ADDR1; nxt_doe = 1'b0; end
      S_HSB:   begin nxt_ctrl = MODE_HSB;   nxt_addr = HSB_ADDR;  nxt_doe = 1'b0; end
      S_UNL0:  begin nxt_ctrl = MODE_UNL;   nxt_dout = 8'h55; end
      S_UNL1:  begin nxt_ctrl = MODE_UNL;   nxt_dout = 8'hAA; end
      S_ERASE: nxt_ctrl = MODE_ERASE;
      S_HSBW:  begin nxt_ctrl = MODE_HSBW;  nxt_dout = 8'hFF; end
      S_XA0:   begin nxt_ctrl = MODE_XAF;   nxt_addr = SIG_ADDR0; nxt_dout = sig0_q; end
      S_XA1:   begin nxt_ctrl = MODE_XAF;   nxt_addr = SIG_ADDR1; nxt_dout = sig1_q; end
      S_LOAD:  begin nxt_ctrl = MODE_LOAD;  nxt_addr = cur_addr;  nxt_dout = byte_q; end
      S_LOCK:  nxt_ctrl = MODE_LOCK;
      default: nxt_doe = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      armed    <= 1'b0;
      recov    <= 1'b0;
      sig0_q   <= '0;
      sig1_q   <= '0;
      byte_q   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      pin_ctrl <= MODE_IDLE;
      pin_addr <= '0;
      pin_dout <= '0;
      pin_doe  <= 1'b0;
    end else if (state == S_IDLE) begin
      if (start_ok) begin
        busy  <= 1'b1;
        done  <= 1'b0;
        err   <= 1'b0;
        state <= S_SIG0;
      end
    end else if (state == S_WAIT) begin
      if (s_valid) begin
        byte_q <= s_data;
        state  <= S_LOAD;
      end
    end else if (go) begin
      pin_ctrl <= nxt_ctrl;
      pin_addr <= nxt_addr;
      pin_dout <= nxt_dout;
      pin_doe  <= nxt_doe;
      armed    <= 1'b1;
    end else if (eng_done) begin
      armed <= 1'b0;
      case (state)
        S_SIG0: begin sig0_q <= pin_din; state <= S_SIG1; end
        S_SIG1: begin
          sig1_q <= pin_din;
          if (sig0_q != SIG_EXP0 || pin_din != SIG_EXP1) begin
            err      <= 1'b1;
            done     <= 1'b1;
            busy     <= 1'b0;
            pin_ctrl <= MODE_IDLE;
            state    <= S_IDLE;
          end else state <= S_HSB;
        end
        S_HSB:   begin recov <= (pin_din != 8'hFF); state <= S_UNL0; end
        S_UNL0:  state <= S_UNL1;
        S_UNL1:  state <= recov ? S_ERASE : (empty ? S_LOCK : S_WAIT);
        S_ERASE: state <= S_HSBW;
        S_HSBW:  state <= S_XA0;
        S_XA0:   state <= S_XA1;
        S_XA1:   begin recov <= 1'b0; state <= S_UNL0; end
        S_LOAD:  state <= last ? S_LOCK : S_WAIT;
        S_LOCK: begin
          done     <= 1'b1;
          busy     <= 1'b0;
          pin_ctrl <= MODE_IDLE;
          pin_doe  <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fps_chk.sv
module fps_chk #(
  parameter int AW       = 16,
  parameter int LOW_CLKS = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          prog_n,
  input logic [7:0]    pin_ctrl,
  input logic [AW-1:0] pin_addr,
  input logic [7:0]    pin_dout,
  input logic          pin_doe,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          s_ready
);
  logic [15:0] lowrun;

  always_ff @(posedge clk) begin
    if (rst) lowrun <= '0;
    else if (!prog_n) lowrun <= lowrun + 1'b1;
    else lowrun <= '0;
  end

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!prog_n && !$past(prog_n)) |-> ($stable(pin_addr) && $stable(pin_ctrl) && $stable(pin_dout)));
  // R8
  low_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_n) |-> (lowrun == 16'(LOW_CLKS)));
  // R5
  doe_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_n |-> pin_doe);
  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> busy);
  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  // R11
  err_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
endmodule

bind flash_prog_seq fps_chk #(.AW(AW), .LOW_CLKS(LOW_CLKS)) u_fps_chk (
  .clk(clk), .rst(rst), .prog_n(prog_n), .pin_ctrl(pin_ctrl),
  .pin_addr(pin_addr), .pin_dout(pin_dout), .pin_doe(pin_doe),
  .busy(busy), .done(done), .err(err), .s_ready(s_ready));

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
  localparam int CLK_P = 10;
  localparam int SETUP = 2, LOWW = 3, HOLD = 2;
  localparam logic [15:0] SA0 = 16'h0030, SA1 = 16'h0031;
  localparam logic [7:0] M_SIG = 8'h10, M_HSB = 8'h11, M_UNL = 8'h20, M_ERA = 8'h21,
                         M_HSBW = 8'h22, M_XAF = 8'h23, M_LOAD = 8'h30, M_LOCK = 8'h40;

  logic clk = 0, rst = 1;
  logic start = 0;
  logic [15:0] start_addr = '0;
  logic [7:0]  start_pages = '0;
  logic s_valid = 0;
  logic [7:0] s_data = '0;
  logic s_ready, busy, done, err, pin_doe, prog_n;
  logic [7:0] pin_ctrl, pin_dout, pin_din;
  logic [15:0] pin_addr;

  int total = 0, bad = 0;
  logic [7:0] t_sig0 = 8'h58, t_sig1 = 8'hD7, t_hsb = 8'hFF;
  logic [31:0] exp_q[$], act_q[$];
  logic [7:0]  st_q[$];
  bit hs_pend = 0;
  int gap = 0;

  flash_prog_seq dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .start_pages(start_pages),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .busy(busy), .done(done), .err(err),
    .pin_ctrl(pin_ctrl), .pin_addr(pin_addr), .pin_dout(pin_dout), .pin_doe(pin_doe),
    .pin_din(pin_din), .prog_n(prog_n));

  always #(CLK_P/2) clk = ~clk;

  // target model: reads answer from mode and address only
  always_comb begin
    pin_din = 8'h00;
    if (pin_ctrl == M_SIG && pin_addr == SA0) pin_din = t_sig0;
    else if (pin_ctrl == M_SIG && pin_addr == SA1) pin_din = t_sig1;
    else if (pin_ctrl == M_HSB) pin_din = t_hsb;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-clock timing reference: setup, width, hold of every strobe
  logic [31:0] prev_pins = '0;
  logic prev_pn = 1;
  int stable_cnt = 0, low_cnt = 0, hold_left = 0;
  always @(negedge clk) begin
    if (!rst) begin
      automatic logic [31:0] cur = {pin_ctrl, pin_addr, pin_dout};
      if (cur == prev_pins) stable_cnt++; else stable_cnt = 0;
      if (hold_left > 0) begin
        if (cur != prev_pins) chk(0, "R9 hold", cur, prev_pins);
        hold_left--;
      end
      if (!prog_n && low_cnt > 0 && cur != prev_pins) chk(0, "R8 pins moved while low", cur, prev_pins);
      if (prev_pn && !prog_n) begin
        chk(stable_cnt >= SETUP, "R7 setup", stable_cnt, SETUP);
        low_cnt = 0;
      end
      if (!prog_n) low_cnt++;
      if (!prev_pn && prog_n) begin
        chk(low_cnt == LOWW, "R8 width", low_cnt, LOWW);
        chk(pin_doe == 1'b1, "R5 doe", pin_doe, 1);
        act_q.push_back(cur);
        hold_left = HOLD;
      end
      prev_pins = cur;
      prev_pn = prog_n;
    end
  end

  // host byte stream with gaps
  always @(negedge clk) begin
    if (hs_pend) void'(st_q.pop_front());
    gap++;
    if (st_q.size() > 0 && (gap % 4) != 3) begin
      s_valid = 1;
      s_data = st_q[0];
    end else s_valid = 0;
    hs_pend = s_valid && s_ready;
  end

  task automatic ev(input logic [7:0] c, input logic [15:0] a, input logic [7:0] d);
    exp_q.push_back({c, a, d});
  endtask

  task automatic pulse_start(input logic [15:0] a, input logic [7:0] n);
    @(negedge clk);
    start = 1; start_addr = a; start_pages = n;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_job(input logic [15:0] a, input logic [7:0] n, input bit secure,
                         input bit good, input int seed, input int extra);
    exp_q.delete(); act_q.delete();
    t_sig0 = 8'h58; t_sig1 = good ? 8'hD7 : 8'h00;
    t_hsb = secure ? 8'hFC : 8'hFF;
    if (good) begin
      if (secure) begin
        ev(M_UNL, 0, 8'h55); ev(M_UNL, 0, 8'hAA); ev(M_ERA, 0, 0); ev(M_HSBW, 0, 8'hFF);
        ev(M_XAF, SA0, 8'h58); ev(M_XAF, SA1, 8'hD7);
      end
      ev(M_UNL, 0, 8'h55); ev(M_UNL, 0, 8'hAA);
      for (int i = 0; i < n * 128; i++) begin
        automatic logic [7:0] b = 8'((i * 13) ^ seed);
        ev(M_LOAD, a + 16'(i), b);
        st_q.push_back(b);
      end
      ev(M_LOCK, 0, 0);
    end
    for (int k = 0; k < extra; k++) st_q.push_back(8'hEE);
    pulse_start(a, n);
    for (int w = 0; w < 40000 && !done; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done && !busy, good ? "R6 done" : "R2 done", {done, busy}, 2'b10);
    chk(err == !good, good ? "R6 err" : "R2 err", err, !good);
    chk(act_q.size() == exp_q.size(), "R5 strobe count", act_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < act_q.size(); i++) begin
      automatic string tag = (exp_q[i][31:24] == M_LOAD) ? "R5" :
                             (exp_q[i][31:24] == M_LOCK) ? "R6" :
                             (exp_q[i][31:24] == M_UNL)  ? "R4" : "R3";
      chk(act_q[i] == exp_q[i], tag, act_q[i], exp_q[i]);
    end
    chk(st_q.size() == extra, "R10 bytes taken", st_q.size(), extra);
    st_q.delete();
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12
    chk({busy, done, err, prog_n, s_ready} == 5'b00010, "R12 reset", {busy, done, err, prog_n, s_ready}, 5'b00010);
    // R2: identification mismatch
    run_job(16'h0080, 8'd1, 0, 0, 0, 0);
    // R1 and R11: unaligned start ignored, held status kept
    act_q.delete();
    pulse_start(16'h0105, 8'd1);
    repeat (20) @(negedge clk);
    chk(!busy, "R1 busy", busy, 0);
    chk(done && err, "R11 held", {done, err}, 2'b11);
    chk(act_q.size() == 0, "R1 no strobe", act_q.size(), 0);
    // R4/R5/R6: unprotected, one page
    run_job(16'h0080, 8'd1, 0, 1, 8'h3C, 0);
    // R3: protected, two pages
    run_job(16'h0200, 8'd2, 1, 1, 8'hA5, 0);
    // R10: zero pages, surplus byte must not be taken
    run_job(16'h0400, 8'd0, 0, 1, 0, 1);
    chk(!s_ready, "R10 ready idle", s_ready, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule